// File: doc/BRIEF.md
# TDM Serial Audio Transmit Framer

This block is the transmit side of a serial audio port. Once per bit period it receives a one-cycle strobe, taken from the falling edge of the bit clock. On that strobe it steps a frame position counter, drives the frame sync level (`ws`) and drives the serial data bit (`sd`). A frame holds a configurable number of channel slots, and every slot has the same configurable bit width. Each sample carries a valid width that may be smaller than the slot. The bits in a slot after the valid sample bits are sent as zero.

Four framing formats are available, chosen by a 2-bit code. The code sets how long the frame sync stays asserted and whether the data lags the sync edge by one bit. Sample words come from an upstream buffer through a request/ready handshake. The block asks for a slot's word while the slot before it is still on the wire. A late word is replaced by zero and flagged. A per-slot enable mask turns off unused slots. A bit-order select picks MSB-first or LSB-first. The frame length settings are held for the whole frame, and new values are taken only when a frame wraps.

Top module: `tdm_tx_framer`

## Requirements
- R1: A frame is `cfg_chans` slots of `cfg_slot_bits` bits each. `frame_start` is high only while bit 0 of slot 0 is being driven.
- R2: Format code 0 (standard, one-bit delay): the first data bit of slot 0 comes one bit period after `ws` falls. Counting sync positions from that fall, `ws` is 0 for the first (chans × slot bits)/2 positions and 1 for the rest.
- R3: Format code 1 (MSB-justified): `ws` is 1 for the first (chans × slot bits)/2 bit periods of the frame, in line with the first data bit.
- R4: Format code 2 (short sync): `ws` is 1 for exactly one bit period per frame, the one carrying bit 0 of slot 0.
- R5: Format code 3 (long sync): `ws` is 1 for the first `cfg_slot_bits` bit periods of the frame.
- R6: In every slot, the first `cfg_data_bits` bits carry the sample held right-aligned in `smp_data`. With `cfg_lsb_first`=0 they run from bit `cfg_data_bits`-1 down to bit 0; with 1 they run from bit 0 up. The remaining bits of the slot are 0, and word bits at or above `cfg_data_bits` have no effect.
- R7: A slot whose bit in `cfg_ch_mask` (bit n = slot n) is 0 is sent as all zeros. The block never requests a word for it and never flags an underrun for it.
- R8: `smp_req` with `smp_slot` asks for the word of the slot after the one being sent. A clock edge with `smp_req` and `smp_ready` both high accepts `smp_data`, and `smp_req` then drops. `smp_slot` holds steady until the next slot begins.
- R9: If an enabled slot begins before its word has been accepted, the slot is sent as zero and `underrun` is high for one clock cycle, the cycle after that strobe.
- R10: `ws`, `sd`, `frame_start` and `underrun` change only in the clock cycle that follows a `bclk_fall` strobe.
- R11: `cfg_fmt`, `cfg_chans`, `cfg_slot_bits` and `cfg_data_bits` take effect only when the last bit of a frame advances to the next frame. Changes during a frame leave that frame as it was.
- R12: Reset leaves the framer on the last bit of a frame, with `sd`, `frame_start` and `underrun` at 0, and with a request for slot 0 raised if slot 0 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_fall | input | 1 | One-cycle strobe at each bit-clock falling edge |
| cfg_fmt | input | 2 | Framing format: 0 standard, 1 MSB-justified, 2 short sync, 3 long sync |
| cfg_chans | input | 4 | Slots per frame (1 to 8) |
| cfg_slot_bits | input | 6 | Bits per slot (1 to 32) |
| cfg_data_bits | input | 6 | Valid sample bits per slot (1 to cfg_slot_bits) |
| cfg_ch_mask | input | 8 | Slot enable, bit n for slot n |
| cfg_lsb_first | input | 1 | 1 sends LSB first, 0 sends MSB first |
| smp_data | input | 32 | Sample word, right-aligned |
| smp_ready | input | 1 | Sample word valid for the requested slot |
| smp_req | output | 1 | Request for the word of slot `smp_slot` |
| smp_slot | output | 3 | Slot index of the pending request |
| ws | output | 1 | Frame sync / word select |
| sd | output | 1 | Serial data |
| frame_start | output | 1 | High during bit 0 of slot 0 |
| underrun | output | 1 | One-cycle pulse: an enabled slot began without its word |

## Verification
Every framing output is registered on the clock edge that sees `bclk_fall`. So `ws`, `sd` and `frame_start` for a bit position are due one cycle after the strobe, and they must hold until the next strobe. The bench leaves three idle cycles between strobes. It reads these outputs both one cycle and three cycles after each strobe and requires the two readings to match. `underrun` lasts one cycle, so it is read only at the falling edge right after the strobe's rising edge. The handshake result is due at the edge where request and ready meet, and it is checked on the next falling edge.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    parameter int MAX_CH   = 8;
    parameter int MAX_SLOT = 32;
    parameter int SMP_W    = MAX_SLOT;

    localparam int CH_W = $clog2(MAX_CH + 1);
    localparam int IDX_W = $clog2(MAX_CH);
    localparam int BW   = $clog2(MAX_SLOT + 1);
    localparam int BI_W = $clog2(MAX_SLOT);
    localparam int FL_W = $clog2(MAX_CH * MAX_SLOT + 1);

    typedef enum logic [1:0] {
        FMT_STD   = 2'd0,
        FMT_MSBJ  = 2'd1,
        FMT_PCM_S = 2'd2,
        FMT_PCM_L = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e            fmt;
        logic [CH_W-1:0] chans;
        logic [BW-1:0]   slot_bits;
        logic [BW-1:0]   data_bits;
    } cfg_t;

    function automatic logic [FL_W-1:0] frame_len(cfg_t c);
        return FL_W'(c.chans) * FL_W'(c.slot_bits);
    endfunction

    // Sync level for the data position pos of a frame built with c.
    function automatic logic ws_level(cfg_t c, logic [FL_W-1:0] pos);
        logic [FL_W-1:0] flen;
        logic [FL_W-1:0] half;
        logic [FL_W-1:0] lead;
        flen = frame_len(c);
        half = flen >> 1;
        lead = (pos == flen - FL_W'(1)) ? '0 : pos + FL_W'(1);
        case (c.fmt)
            FMT_STD:   return lead >= half;
            FMT_MSBJ:  return pos < half;
            FMT_PCM_S: return pos == '0;
            default:   return pos < FL_W'(c.slot_bits);
        endcase
    endfunction

endpackage

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing
    import tdm_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_fall,
    input  cfg_t             cfg_in,
    output cfg_t             cfg_q,
    output cfg_t             cfg_eff,
    output logic [IDX_W-1:0] nslot,
    output logic [BI_W-1:0]  bit_idx,
    output logic             slot_begin,
    output logic             ws,
    output logic             frame_start
);

    logic [IDX_W-1:0] slot_idx;
    logic [FL_W-1:0]  dpos;
    logic             last_bit;
    logic             last_slot;
    logic             wrap;

    always_comb begin
        last_bit   = (BW'(bit_idx) == cfg_q.slot_bits - BW'(1));
        last_slot  = (CH_W'(slot_idx) == cfg_q.chans - CH_W'(1));
        wrap       = last_bit && last_slot;
        cfg_eff    = wrap ? cfg_in : cfg_q;
        slot_begin = last_bit;
        if (!last_bit)
            nslot = slot_idx;
        else if (last_slot)
            nslot = '0;
        else
            nslot = slot_idx + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= cfg_in;
            slot_idx <= IDX_W'(cfg_in.chans - CH_W'(1));
            bit_idx  <= BI_W'(cfg_in.slot_bits - BW'(1));
            dpos     <= frame_len(cfg_in) - FL_W'(1);
        end else if (bclk_fall) begin
            cfg_q    <= cfg_eff;
            slot_idx <= nslot;
            bit_idx  <= last_bit ? '0 : bit_idx + BI_W'(1);
            dpos     <= wrap ? '0 : dpos + FL_W'(1);
        end
    end

    assign ws          = ws_level(cfg_q, dpos);
    assign frame_start = (dpos == '0);

endmodule

// File: rtl/tdm_tx_fetch.sv
module tdm_tx_fetch
    import tdm_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] nslot,
    input  logic [CH_W-1:0]  chans_eff,
    input  logic [MAX_CH-1:0] ch_mask,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             smp_ready,
    output logic             smp_req,
    output logic [IDX_W-1:0] smp_slot,
    output logic [SMP_W-1:0] word,
    output logic             word_ok
);

    logic [IDX_W-1:0] pf_slot;
    logic             hold_valid;
    logic [SMP_W-1:0] hold_data;

    assign smp_slot = pf_slot;
    assign smp_req  = !hold_valid && ch_mask[pf_slot];
    // A word handed over on the very edge the slot starts is still in time.
    assign word     = hold_valid ? hold_data : smp_data;
    assign word_ok  = hold_valid || (smp_req && smp_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_slot    <= '0;
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (load) begin
            hold_valid <= 1'b0;
            pf_slot    <= (CH_W'(nslot) == chans_eff - CH_W'(1)) ? '0 : nslot + IDX_W'(1);
        end else if (smp_req && smp_ready) begin
            hold_data  <= smp_data;
            hold_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IDX_W-1:0]  nslot,
    input  logic [MAX_CH-1:0] ch_mask,
    input  logic              lsb_first,
    input  logic [SMP_W-1:0]  word,
    input  logic              word_ok,
    input  logic [BI_W-1:0]   bit_idx,
    input  logic [BW-1:0]     data_bits,
    output logic              sd,
    output logic              underrun
);

    logic [SMP_W-1:0] cur;
    logic             lsb_q;
    logic             slot_on;
    logic [BW-1:0]    pos;
    logic [BW-1:0]    sel;

    assign slot_on = ch_mask[nslot];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            lsb_q    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (load) begin
                cur      <= (slot_on && word_ok) ? word : '0;
                lsb_q    <= lsb_first;
                underrun <= slot_on && !word_ok;
            end
        end
    end

    always_comb begin
        pos = BW'(bit_idx);
        sel = lsb_q ? pos : data_bits - BW'(1) - pos;
        if (pos >= data_bits)
            sd = 1'b0;
        else
            sd = cur[sel[BI_W-1:0]];
    end

endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
    import tdm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_fall,
    input  logic [1:0]        cfg_fmt,
    input  logic [CH_W-1:0]   cfg_chans,
    input  logic [BW-1:0]     cfg_slot_bits,
    input  logic [BW-1:0]     cfg_data_bits,
    input  logic [MAX_CH-1:0] cfg_ch_mask,
    input  logic              cfg_lsb_first,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              smp_ready,
    output logic              smp_req,
    output logic [IDX_W-1:0]  smp_slot,
    output logic              ws,
    output logic              sd,
    output logic              frame_start,
    output logic              underrun
);

    cfg_t             cfg_in;
    cfg_t             cfg_q;
    cfg_t             cfg_eff;
    logic [IDX_W-1:0] nslot;
    logic [BI_W-1:0]  bit_idx;
    logic             slot_begin;
    logic             load;
    logic [SMP_W-1:0] word;
    logic             word_ok;

    always_comb begin
        cfg_in.fmt       = fmt_e'(cfg_fmt);
        cfg_in.chans     = cfg_chans;
        cfg_in.slot_bits = cfg_slot_bits;
        cfg_in.data_bits = cfg_data_bits;
    end

    assign load = bclk_fall && slot_begin;

    tdm_tx_timing u_timing (
        .clk         (clk),
        .rst         (rst),
        .bclk_fall   (bclk_fall),
        .cfg_in      (cfg_in),
        .cfg_q       (cfg_q),
        .cfg_eff     (cfg_eff),
        .nslot       (nslot),
        .bit_idx     (bit_idx),
        .slot_begin  (slot_begin),
        .ws          (ws),
        .frame_start (frame_start)
    );

    tdm_tx_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .nslot     (nslot),
        .chans_eff (cfg_eff.chans),
        .ch_mask   (cfg_ch_mask),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .smp_req   (smp_req),
        .smp_slot  (smp_slot),
        .word      (word),
        .word_ok   (word_ok)
    );

    tdm_tx_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .nslot     (nslot),
        .ch_mask   (cfg_ch_mask),
        .lsb_first (cfg_lsb_first),
        .word      (word),
        .word_ok   (word_ok),
        .bit_idx   (bit_idx),
        .data_bits (cfg_q.data_bits),
        .sd        (sd),
        .underrun  (underrun)
    );

endmodule

// File: rtl/tdm_tx_framer_chk.sv
module tdm_tx_framer_chk
    import tdm_tx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bclk_fall,
    input logic             smp_req,
    input logic             smp_ready,
    input logic [IDX_W-1:0] smp_slot,
    input logic             ws,
    input logic             sd,
    input logic             frame_start,
    input logic             underrun,
    input logic [1:0]       fmt_q
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R10: outputs move only after a strobe
    p_hold_between_strobes_r10: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(bclk_fall) |-> ($stable(ws) && $stable(sd) && $stable(frame_start)));

    // R9: underrun marks a slot start
    p_underrun_after_strobe_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
        underrun |-> $past(bclk_fall));

    // R1: frame start entered on a strobe
    p_frame_start_strobe_r1: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(frame_start) |-> $past(bclk_fall));

    // R4: short sync only on the first bit of a frame
    p_short_sync_r4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (fmt_q == 2'd2 && ws) |-> frame_start);

    // R8: a pending request keeps its slot index
    p_req_slot_stable_r8: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (smp_req && !smp_ready && !bclk_fall) |=> $stable(smp_slot));

endmodule

bind tdm_tx_framer tdm_tx_framer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bclk_fall   (bclk_fall),
    .smp_req     (smp_req),
    .smp_ready   (smp_ready),
    .smp_slot    (smp_slot),
    .ws          (ws),
    .sd          (sd),
    .frame_start (frame_start),
    .underrun    (underrun),
    .fmt_q       (cfg_q.fmt)
);

// File: tb/tb_tdm_tx_framer.sv
module tb_tdm_tx_framer;
    import tdm_tx_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bclk_fall = 1'b0;
    logic [1:0]        cfg_fmt = 2'd0;
    logic [CH_W-1:0]   cfg_chans = 4'd2;
    logic [BW-1:0]     cfg_slot_bits = 6'd16;
    logic [BW-1:0]     cfg_data_bits = 6'd16;
    logic [MAX_CH-1:0] cfg_ch_mask = 8'h03;
    logic              cfg_lsb_first = 1'b0;
    logic [SMP_W-1:0]  smp_data = '0;
    logic              smp_ready = 1'b0;
    logic              smp_req;
    logic [IDX_W-1:0]  smp_slot;
    logic              ws, sd, frame_start, underrun;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit feed_en = 1'b1;
    logic [31:0] pat [8];

    int m_fmt, m_ch, m_sb, m_db, m_lsb;
    logic [7:0] m_mask;

    tdm_tx_framer dut (
        .clk(clk), .rst(rst), .bclk_fall(bclk_fall),
        .cfg_fmt(cfg_fmt), .cfg_chans(cfg_chans), .cfg_slot_bits(cfg_slot_bits),
        .cfg_data_bits(cfg_data_bits), .cfg_ch_mask(cfg_ch_mask),
        .cfg_lsb_first(cfg_lsb_first), .smp_data(smp_data), .smp_ready(smp_ready),
        .smp_req(smp_req), .smp_slot(smp_slot), .ws(ws), .sd(sd),
        .frame_start(frame_start), .underrun(underrun)
    );

    always #5 clk = ~clk;

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // One clock: offer the requested word, then let an edge pass.
    task automatic tick();
        smp_ready = feed_en && smp_req;
        smp_data  = pat[smp_slot];
        @(posedge clk);
        @(negedge clk);
        smp_ready = 1'b0;
    endtask

    task automatic set_cfg(input int f, input int ch, input int sb, input int db,
                           input logic [7:0] mk, input int lsb);
        cfg_fmt = 2'(f); cfg_chans = CH_W'(ch); cfg_slot_bits = BW'(sb);
        cfg_data_bits = BW'(db); cfg_ch_mask = mk; cfg_lsb_first = 1'(lsb);
        m_fmt = f; m_ch = ch; m_sb = sb; m_db = db; m_mask = mk; m_lsb = lsb;
    endtask

    task automatic do_reset(input int feed_ticks);
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        repeat (feed_ticks) tick();
    endtask

    // One bit period: strobe, then three idle clocks.
    task automatic step_bit(output logic w, output logic s, output logic f, output logic u);
        logic w1, s1;
        bclk_fall = 1'b1;
        tick();
        bclk_fall = 1'b0;
        u = underrun; w1 = ws; s1 = sd;
        tick(); tick(); tick();
        w = ws; s = sd; f = frame_start;
        chk("R10", {w1, s1}, {w, s}, "ws/sd held");
    endtask

    task automatic run_bits(input string ws_tag, input string sd_tag, input int lo,
                            input int hi, input bit nodata, output int urc);
        logic w, s, f, u;
        urc = 0;
        for (int dp = lo; dp <= hi; dp++) begin
            int fl, half, lead, slot, b, ew, es;
            step_bit(w, s, f, u);
            if (u) urc++;
            fl = m_ch * m_sb; half = fl / 2;
            slot = dp / m_sb; b = dp % m_sb;
            case (m_fmt)
                0: begin lead = (dp == fl - 1) ? 0 : dp + 1; ew = (lead >= half); end
                1: ew = (dp < half);
                2: ew = (dp == 0);
                default: ew = (dp < m_sb);
            endcase
            if (nodata || !m_mask[slot] || b >= m_db) es = 0;
            else if (m_lsb != 0) es = pat[slot][b];
            else es = pat[slot][m_db - 1 - b];
            chk(ws_tag, w, ew, $sformatf("ws at %0d", dp));
            chk(sd_tag, s, es, $sformatf("sd at %0d", dp));
            chk("R1", f, (dp == 0), $sformatf("frame_start at %0d", dp));
        end
    endtask

    task automatic run_frames(input string ws_tag, input string sd_tag, input int n);
        int urc;
        for (int k = 0; k < n; k++) begin
            run_bits(ws_tag, sd_tag, 0, m_ch * m_sb - 1, 1'b0, urc);
            chk("R9", urc, 0, "underrun with words supplied");
        end
    endtask

    task automatic t_reset_std();
        pat[0] = 32'h0000_A5C3; pat[1] = 32'hFFFF_1E87;
        set_cfg(0, 2, 16, 16, 8'h03, 0);
        feed_en = 1'b1;
        do_reset(0);
        chk("R12", ws, 0, "ws after reset");
        chk("R12", sd, 0, "sd after reset");
        chk("R12", frame_start, 0, "frame_start after reset");
        chk("R12", underrun, 0, "underrun after reset");
        chk("R8", smp_req, 1, "slot 0 requested after reset");
        chk("R8", smp_slot, 0, "requested slot after reset");
        tick();
        chk("R8", smp_req, 0, "request dropped after accept");
        run_frames("R2", "R6", 2);
    endtask

    task automatic t_msb_justified();
        pat[0] = 32'hFFFF_FF2D; pat[1] = 32'h0000_0013;
        pat[2] = 32'hAAAA_AA3A; pat[3] = 32'h5555_5506;
        set_cfg(1, 4, 8, 6, 8'h0F, 0);
        do_reset(4);
        run_frames("R3", "R6", 2);
    endtask

    task automatic t_short_sync_mask();
        pat[0] = 32'h0000_00B1; pat[1] = 32'h0000_00FF;
        pat[2] = 32'h0000_004E; pat[3] = 32'h0000_0093;
        set_cfg(2, 4, 8, 8, 8'h0B, 1);
        do_reset(0);
        chk("R12", smp_req, 1, "request slot 0 enabled");
        rst = 1'b1; cfg_ch_mask = 8'h0A; m_mask = 8'h0A;
        do_reset(0);
        chk("R7", smp_req, 0, "no request for disabled slot 0");
        cfg_ch_mask = 8'h0B; m_mask = 8'h0B;
        do_reset(4);
        run_frames("R4", "R7", 2);
    endtask

    task automatic t_long_sync();
        pat[0] = 32'hFFFF_F2C5; pat[1] = 32'h0000_0371; pat[2] = 32'h1234_56A8;
        set_cfg(3, 3, 12, 10, 8'h07, 0);
        do_reset(4);
        run_frames("R5", "R6", 2);
    endtask

    task automatic t_underrun();
        int urc;
        pat[0] = 32'h0000_00C7; pat[1] = 32'h0000_0055;
        set_cfg(1, 2, 8, 8, 8'h01, 0);
        feed_en = 1'b0;
        do_reset(4);
        run_bits("R3", "R9", 0, 15, 1'b1, urc);
        chk("R9", urc, 1, "underrun pulses, one enabled slot starved");
        feed_en = 1'b1;
        run_bits("R3", "R6", 0, 15, 1'b0, urc);
        chk("R9", urc, 0, "no underrun once fed at slot edge");
    endtask

    task automatic t_cfg_boundary();
        int urc;
        pat[0] = 32'h0000_00E6; pat[1] = 32'h0000_0039;
        pat[2] = 32'h0000_0008; pat[3] = 32'h0000_000D;
        set_cfg(0, 2, 8, 8, 8'h0F, 0);
        do_reset(4);
        run_bits("R2", "R6", 0, 4, 1'b0, urc);
        cfg_fmt = 2'd3; cfg_chans = 4'd4; cfg_slot_bits = 6'd8; cfg_data_bits = 6'd4;
        run_bits("R11", "R11", 5, 15, 1'b0, urc);
        m_fmt = 3; m_ch = 4; m_sb = 8; m_db = 4;
        run_bits("R11", "R11", 0, 31, 1'b0, urc);
        chk("R11", urc, 0, "no underrun across format change");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) pat[i] = '0;
        @(negedge clk);
        t_reset_std();
        t_msb_justified();
        t_short_sync_mask();
        t_long_sync();
        t_underrun();
        t_cfg_boundary();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule